// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a small fully associative translation buffer. Each slot holds one virtual tag that covers a pair of neighbouring pages, an even one and an odd one. For each half it holds a physical frame number, a cache attribute, a dirty bit and a valid bit. A per-slot page mask removes low tag bits from the compare, so one slot can cover a larger page. A global bit makes the slot match under any address-space ID.

The lookup port is purely combinational. It takes a virtual page-pair number and an address-space ID. It returns a hit flag, the index of the matching slot, and that slot's contents in packed form. The same port serves both translation and probing.

Software-style maintenance goes through three other paths:
- an indexed write port that replaces a whole slot on a clock edge;
- an indexed combinational read port whose strobe also steps a round-robin victim pointer;
- a global flush.

Segment decoding, fault generation and table walking happen outside the block.

Top module: `ppair_tlb`

## Requirements
- R1: A slot matches a lookup when every tag bit that is 0 in the slot's mask is equal between the lookup number and the stored number, and in addition the slot's global bit is 1 or its stored ID equals the lookup ID.
- R2: A slot whose even and odd valid bits are both 0 never matches.
- R3: When several slots match, `lk_hit` is 1 and `lk_idx` gives the lowest matching index.
- R4: With no match, `lk_hit` is 0, and `lk_idx`, `lk_mask`, `lk_hi`, `lk_lo0` and `lk_lo1` are all zero.
- R5: The packed high word holds the tag at bits [VPN_W+10:11], zeros at bits [10:ASID_W], and the ID at bits [ASID_W-1:0]. Each packed low word holds the frame at [PFN_W+5:6], the cache attribute at [5:3], dirty at bit 2, valid at bit 1 and the slot's global bit at bit 0. The global bit appears in both low words. The mask is returned unchanged.
- R6: A write with `wr_en` at an index below ENTRIES replaces every field of that slot at the clock edge. From the next cycle on, the old tag no longer matches and the new tag does.
- R7: A write whose index is ENTRIES or more changes no slot. A read at such an index returns all zeros.
- R8: `flush` clears every slot and sets `nxt_idx` to 0 at the clock edge. It takes precedence over a write and over an advance in the same cycle.
- R9: Each cycle with `rd_adv` high and no flush, `nxt_idx` steps by one, and it wraps from ENTRIES-1 to 0. Otherwise it holds.
- R10: An asserted `rst_n` clears every slot and the victim pointer asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup page-pair number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | IDX_W | Index of the matching slot |
| lk_mask | output | VPN_W | Mask of the matching slot |
| lk_hi | output | HI_W | Packed tag and ID of the matching slot |
| lk_lo0 | output | LO_W | Packed even half of the matching slot |
| lk_lo1 | output | LO_W | Packed odd half of the matching slot |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Write index |
| wr_mask | input | VPN_W | New page mask |
| wr_vpn | input | VPN_W | New tag |
| wr_asid | input | ASID_W | New ID |
| wr_glob | input | 1 | New global bit |
| wr_pfn0 | input | PFN_W | New even frame |
| wr_ca0 | input | 3 | New even cache attribute |
| wr_d0 | input | 1 | New even dirty bit |
| wr_v0 | input | 1 | New even valid bit |
| wr_pfn1 | input | PFN_W | New odd frame |
| wr_ca1 | input | 3 | New odd cache attribute |
| wr_d1 | input | 1 | New odd dirty bit |
| wr_v1 | input | 1 | New odd valid bit |
| rd_idx | input | IDX_W+1 | Read index |
| rd_adv | input | 1 | Read strobe that steps the victim pointer |
| rd_mask | output | VPN_W | Mask of the slot read |
| rd_hi | output | HI_W | Packed tag and ID of the slot read |
| rd_lo0 | output | LO_W | Packed even half of the slot read |
| rd_lo1 | output | LO_W | Packed odd half of the slot read |
| flush | input | 1 | Clear all slots and the victim pointer |
| nxt_idx | output | IDX_W | Round-robin victim index |

## Verification
The bench uses the defaults:
- ENTRIES=16, so IDX_W is 4;
- VPN_W=19, ASID_W=8, PFN_W=24, which give 30-bit packed words.

Because the write and read indices are one bit wider than IDX_W, indices 16 to 31 can be driven. This exercises the ignored-write and zero-read cases.

With 16 slots, a full pointer wrap from 15 back to 0 takes sixteen strobes and is checked directly. A masked slot that overlaps an exact slot at a higher index exercises the lowest-index rule.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  parameter int VPN_W  = 19;
  parameter int ASID_W = 8;
  parameter int PFN_W  = 24;
  parameter int CA_W   = 3;
  localparam int HI_W  = VPN_W + 11;
  localparam int LO_W  = PFN_W + 6;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  ca;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [VPN_W-1:0]  mask;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    half_t             ev;
    half_t             od;
  } slot_t;

  function automatic logic [HI_W-1:0] pack_hi(input slot_t s);
    logic [HI_W-1:0] r;
    r = '0;
    r[HI_W-1:11]    = s.vpn;
    r[ASID_W-1:0]   = s.asid;
    return r;
  endfunction

  function automatic logic [LO_W-1:0] pack_lo(input half_t h, input logic g);
    logic [LO_W-1:0] r;
    r = '0;
    r[LO_W-1:6] = h.pfn;
    r[5:3]      = h.ca;
    r[2]        = h.dirty;
    r[1]        = h.valid;
    r[0]        = g;
    return r;
  endfunction
endpackage

// File: rtl/ptlb_slot.sv
module ptlb_slot
  import ptlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              clr,
  input  slot_t             wdata,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output slot_t             ent,
  output logic              match
);
  slot_t ent_q, ent_d;
  logic  load;

  // next-state: flush wins over write
  always_comb begin
    ent_d = ent_q;
    load  = 1'b0;
    if (clr) begin
      ent_d = '0;
      load  = 1'b1;
    end else if (we) begin
      ent_d = wdata;
      load  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ent_q <= '0;
    else if (load) ent_q <= ent_d;
  end

  logic present, tag_eq, id_ok;
  always_comb begin
    present = ent_q.ev.valid | ent_q.od.valid;
    tag_eq  = (((lk_vpn ^ ent_q.vpn) & ~ent_q.mask) == '0);
    id_ok   = ent_q.glob | (lk_asid == ent_q.asid);
    match   = present & tag_eq & id_ok;
  end

  assign ent = ent_q;
endmodule

// File: rtl/ptlb_pick.sv
module ptlb_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // descending scan: the last assignment is the lowest set index
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        hit = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);
  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = clr | adv;
    if (clr)                ptr_d = '0;
    else if (ptr_q == LAST) ptr_d = '0;
    else                    ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign idx = ptr_q;
endmodule

// File: rtl/ppair_tlb.sv
module ppair_tlb
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PIDX_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [VPN_W-1:0]  lk_mask,
  output logic [HI_W-1:0]   lk_hi,
  output logic [LO_W-1:0]   lk_lo0,
  output logic [LO_W-1:0]   lk_lo1,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [2:0]        wr_ca0,
  input  logic              wr_d0,
  input  logic              wr_v0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic [2:0]        wr_ca1,
  input  logic              wr_d1,
  input  logic              wr_v1,
  input  logic [PIDX_W-1:0] rd_idx,
  input  logic              rd_adv,
  output logic [VPN_W-1:0]  rd_mask,
  output logic [HI_W-1:0]   rd_hi,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  input  logic              flush,
  output logic [IDX_W-1:0]  nxt_idx
);
  slot_t              wdata;
  slot_t              ents  [ENTRIES];
  logic [ENTRIES-1:0] we_vec;
  logic [ENTRIES-1:0] match_vec;

  always_comb begin
    wdata          = '0;
    wdata.mask     = wr_mask;
    wdata.vpn      = wr_vpn;
    wdata.asid     = wr_asid;
    wdata.glob     = wr_glob;
    wdata.ev.pfn   = wr_pfn0;
    wdata.ev.ca    = wr_ca0;
    wdata.ev.dirty = wr_d0;
    wdata.ev.valid = wr_v0;
    wdata.od.pfn   = wr_pfn1;
    wdata.od.ca    = wr_ca1;
    wdata.od.dirty = wr_d1;
    wdata.od.valid = wr_v1;
  end

  // indices at or above ENTRIES select no slot
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign we_vec[i] = wr_en & (wr_idx == PIDX_W'(i));
    ptlb_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we_vec[i]),
      .clr     (flush),
      .wdata   (wdata),
      .lk_vpn  (lk_vpn),
      .lk_asid (lk_asid),
      .ent     (ents[i]),
      .match   (match_vec[i])
    );
  end

  ptlb_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
    .req (match_vec),
    .hit (lk_hit),
    .idx (lk_idx)
  );

  ptlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (rd_adv),
    .clr   (flush),
    .idx   (nxt_idx)
  );

  slot_t lk_sel, rd_sel;
  always_comb begin
    lk_sel = '0;
    rd_sel = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (lk_hit && (lk_idx == IDX_W'(k))) lk_sel = ents[k];
      if (rd_idx == PIDX_W'(k))            rd_sel = ents[k];
    end
  end

  always_comb begin
    lk_mask = lk_sel.mask;
    lk_hi   = pack_hi(lk_sel);
    lk_lo0  = pack_lo(lk_sel.ev, lk_sel.glob);
    lk_lo1  = pack_lo(lk_sel.od, lk_sel.glob);
    rd_mask = rd_sel.mask;
    rd_hi   = pack_hi(rd_sel);
    rd_lo0  = pack_lo(rd_sel.ev, rd_sel.glob);
    rd_lo1  = pack_lo(rd_sel.od, rd_sel.glob);
  end
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PIDX_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              rd_adv,
  input logic [IDX_W-1:0]  nxt_idx,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [HI_W-1:0]   lk_hi,
  input logic [LO_W-1:0]   lk_lo0,
  input logic              wr_en,
  input logic [PIDX_W-1:0] wr_idx,
  input logic [VPN_W-1:0]  wr_vpn,
  input logic [ASID_W-1:0] wr_asid,
  input logic [PIDX_W-1:0] rd_idx,
  input logic [HI_W-1:0]   rd_hi
);
  logic [HI_W-1:0]  exp_hi;
  logic [IDX_W-1:0] ptr_next;
  always_comb begin
    exp_hi = '0;
    exp_hi[HI_W-1:11]  = wr_vpn;
    exp_hi[ASID_W-1:0] = wr_asid;
    ptr_next = (nxt_idx == IDX_W'(ENTRIES - 1)) ? '0 : nxt_idx + 1'b1;
  end

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (nxt_idx == '0) && !lk_hit);

  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !flush) |=> nxt_idx == $past(ptr_next));

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_adv && !flush) |=> $stable(nxt_idx));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_idx == '0) && (lk_hi == '0) && (lk_lo0 == '0));

  assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && (wr_idx < PIDX_W'(ENTRIES))) |=>
      ((rd_idx != $past(wr_idx)) || (rd_hi == $past(exp_hi))));
endmodule

bind ppair_tlb ptlb_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/sim_ppair_tlb.sv
module sim_ppair_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [18:0] lk_vpn, wr_mask, wr_vpn, lk_mask, rd_mask;
  logic [7:0]  lk_asid, wr_asid;
  logic        lk_hit, wr_en, wr_glob, wr_d0, wr_v0, wr_d1, wr_v1, rd_adv, flush;
  logic [3:0]  lk_idx, nxt_idx;
  logic [29:0] lk_hi, lk_lo0, lk_lo1, rd_hi, rd_lo0, rd_lo1;
  logic [4:0]  wr_idx, rd_idx;
  logic [23:0] wr_pfn0, wr_pfn1;
  logic [2:0]  wr_ca0, wr_ca1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ppair_tlb #(.ENTRIES(N)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [18:0] m, input logic [18:0] v,
                     input logic [7:0] a, input logic g,
                     input logic [23:0] p0, input logic [2:0] c0, input logic d0, input logic v0,
                     input logic [23:0] p1, input logic [2:0] c1, input logic d1, input logic v1);
    @(negedge clk);
    wr_idx = 5'(idx); wr_mask = m; wr_vpn = v; wr_asid = a; wr_glob = g;
    wr_pfn0 = p0; wr_ca0 = c0; wr_d0 = d0; wr_v0 = v0;
    wr_pfn1 = p1; wr_ca1 = c1; wr_d1 = d1; wr_v1 = v1;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [18:0] v, input logic [7:0] a);
    lk_vpn = v; lk_asid = a; #1;
  endtask

  task automatic adv(input int n);
    @(negedge clk);
    rd_adv = 1'b1;
    repeat (n) @(negedge clk);
    rd_adv = 1'b0;
  endtask

  localparam int NV = 9;
  localparam int TV_VPN [NV] = '{'h100, 'h100, 'h200, 'h30A, 'h310, 'h400, 'h305, 'h101, 'h305};
  localparam int TV_ID  [NV] = '{5,     6,     'h33,  9,     9,     1,     9,     5,     8};
  localparam int TV_HIT [NV] = '{1,     0,     1,     1,     0,     0,     1,     0,     0};
  localparam int TV_IDX [NV] = '{0,     0,     1,     2,     0,     0,     2,     0,     0};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_adv = 0; flush = 0; wr_idx = 0; rd_idx = 0;
    wr_mask = 0; wr_vpn = 0; wr_asid = 0; wr_glob = 0;
    wr_pfn0 = 0; wr_ca0 = 0; wr_d0 = 0; wr_v0 = 0;
    wr_pfn1 = 0; wr_ca1 = 0; wr_d1 = 0; wr_v1 = 0;
    lk_vpn = 0; lk_asid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    look(0, 0);
    chk("R10 reset lk_hit", lk_hit, 0);
    chk("R10 reset nxt_idx", nxt_idx, 0);
    chk("R10 reset rd_hi", rd_hi, 0);

    put(0, 0,     'h100, 5, 0, 'hABC, 3, 1, 1, 'hDEF, 2, 0, 0);
    put(1, 0,     'h200, 7, 1, 0,     0, 0, 0, 'h123, 0, 1, 1);
    put(2, 'hF,   'h300, 9, 0, 'h11,  0, 0, 1, 'h22,  0, 0, 1);
    put(3, 0,     'h400, 1, 0, 'h33,  0, 1, 0, 'h44,  0, 1, 0);
    put(4, 0,     'h305, 9, 0, 'h55,  0, 0, 1, 0,     0, 0, 0);

    // R1 R2 R3 R4 table of lookups
    for (int k = 0; k < NV; k++) begin
      look(19'(TV_VPN[k]), 8'(TV_ID[k]));
      chk($sformatf("R1 R2 R3 vec %0d hit", k), lk_hit, 64'(TV_HIT[k]));
      chk($sformatf("R3 vec %0d idx", k), lk_idx, 64'(TV_IDX[k]));
      if (TV_HIT[k] == 0) chk($sformatf("R4 vec %0d lo0", k), lk_lo0, 0);
    end

    // R5 packing
    look('h100, 5);
    chk("R5 lk_hi", lk_hi, 30'h80005);
    chk("R5 lk_lo0", lk_lo0, 30'h2AF1E);
    chk("R5 lk_lo1", lk_lo1, 30'h37BD0);
    rd_idx = 1; #1;
    chk("R5 rd_lo0 global", rd_lo0, 30'h1);
    chk("R5 rd_lo1 global", rd_lo1, 30'h48C7);
    rd_idx = 2; #1;
    chk("R5 rd_mask", rd_mask, 19'hF);

    // R7 out-of-range write and read
    put(16, 0, 'h500, 2, 0, 'h66, 0, 0, 1, 0, 0, 0, 0);
    look('h500, 2);
    chk("R7 ignored write lookup", lk_hit, 0);
    rd_idx = 0; #1;
    chk("R7 slot 0 intact", rd_hi, 30'h80005);
    rd_idx = 16; #1;
    chk("R7 read beyond", rd_hi, 0);
    rd_idx = 31; #1;
    chk("R7 read beyond lo0", rd_lo0, 0);

    // R6 overwrite
    put(0, 0, 'h600, 5, 0, 'h1, 0, 0, 1, 0, 0, 0, 0);
    look('h100, 5);
    chk("R6 old tag gone", lk_hit, 0);
    look('h600, 5);
    chk("R6 new tag hit", lk_hit, 1);
    chk("R6 new tag idx", lk_idx, 0);
    chk("R6 new lo1", lk_lo1, 0);

    // R9 pointer
    adv(15);
    chk("R9 ptr 15", nxt_idx, 15);
    adv(1);
    chk("R9 ptr wrap", nxt_idx, 0);
    adv(2);
    chk("R9 ptr 2", nxt_idx, 2);

    // R8 flush
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    chk("R8 ptr cleared", nxt_idx, 0);
    look('h200, 7);
    chk("R8 slot gone", lk_hit, 0);
    rd_idx = 1; #1;
    chk("R8 rd cleared", rd_hi, 0);

    // R8 flush beats write and advance
    @(negedge clk);
    flush = 1; rd_adv = 1; wr_en = 1; wr_idx = 5; wr_vpn = 'h700; wr_asid = 3; wr_v0 = 1; wr_mask = 0; wr_glob = 0;
    @(negedge clk);
    flush = 0; rd_adv = 0; wr_en = 0;
    look('h700, 3);
    chk("R8 flush beats write", lk_hit, 0);
    chk("R8 flush beats advance", nxt_idx, 0);

    // R10 asynchronous reset mid-run
    put(6, 0, 'h710, 4, 0, 'h9, 0, 0, 1, 0, 0, 0, 0);
    adv(3);
    look('h710, 4);
    chk("R10 precondition hit", lk_hit, 1);
    #2 rst_n = 0; #1;
    chk("R10 async clear hit", lk_hit, 0);
    chk("R10 async clear ptr", nxt_idx, 0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule